// File: doc/BRIEF.md
# Integer Bytecode Stack Processor

This block is a small sequenced processor that runs a byte-oriented, integer-only stack bytecode. Arithmetic works on an operand stack of registers instead of a single accumulator. The block holds a byte-wide program memory, a small file of local-variable registers and a program counter. A fetch/decode/execute sequencer reads each opcode and its inline operand bytes. It then updates the stack, the locals or the counter, and stops when a return instruction runs or when a fault occurs.

Before a run, software fills the program memory through a byte write port. Locals can be preloaded through a word write port. The `start` pulse begins execution at address 0 with an empty stack. At the end of a run, `done` rises. `result` then holds the top of the stack if the run ended through a return, and `error` marks a stack fault, a bad local index or an undefined opcode. Locals keep their values across runs, so a later program can read what an earlier one left behind.

Each single-byte instruction takes two cycles: a fetch cycle and an execute cycle. Each three-byte instruction takes four cycles, because the two operand bytes are read in two extra cycles before the execute cycle.

Top module: `stack_cpu`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `error` are 0, `result` is 0 and all locals are 0.
- R2: A `start` pulse while idle clears `done`, `error` and `result`, empties the stack and sets the counter to 0. `busy` is high on the next cycle. A one-byte instruction takes 2 cycles and a three-byte instruction takes 4. At the clock edge that executes the terminating instruction, `busy` falls and `done` rises.
- R3: The following one-byte opcodes move values between constants, locals and the stack. 0x10+k pushes the constant k, for k from 0 to 7. 0x20+i pushes local i. 0x24+i pops the top into local i. The index i runs from 0 to 3.
- R4: 0x30 pops two entries and pushes their sum. 0x31 pops two entries and pushes their product. Both results wrap at 32 bits.
- R5: 0x40 is three bytes long: the opcode, a local index byte, and a signed 8-bit increment. It adds the sign-extended increment to that local and leaves the stack unchanged. An index byte of 4 or more is a fault.
- R6: 0x50 and 0x51 are three bytes long. Each pops the top entry T and then the deeper entry D, and compares them as signed values. 0x50 branches when D <= T. 0x51 branches when D < T. A taken branch goes to the opcode's address plus a signed 16-bit offset, high byte first. A branch that is not taken continues 3 bytes after the opcode.
- R7: 0x52 is three bytes long and always jumps to the opcode's address plus its signed 16-bit offset.
- R8: 0x60 ends the run with `done`=1 and `error`=0, and copies the top entry to `result`. `result` holds that value until the next start.
- R9: A push onto a stack that already holds 16 entries sets `error` and `done` and halts. Exactly 16 pushes do not fault.
- R10: An instruction that needs more entries than the stack holds sets `error` and `done` and halts. This covers arithmetic, store, branch, and return on an empty stack.
- R11: Any opcode outside the table above (for example 0x00 or 0xFF) sets `error` and `done` and halts.
- R12: Locals written through the load port before a run, or changed by a run, keep their values into later runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program byte write enable (taken while idle) |
| prog_addr | input | 6 | Program byte address |
| prog_data | input | 8 | Program byte value |
| local_we | input | 1 | Local preload write enable (taken while idle) |
| local_idx | input | 2 | Local index to preload |
| local_data | input | 32 | Local preload value |
| start | input | 1 | Begin execution at address 0 |
| busy | output | 1 | Program running |
| done | output | 1 | Run has ended |
| error | output | 1 | Run ended on a fault |
| result | output | 32 | Top of stack captured by return |

## Verification
The hardest situations to reach from the ports are the stack boundary cases. One is a program that pushes exactly sixteen entries and then returns; another pushes a seventeenth. Both need straight-line programs built for that purpose, and the bench writes them and checks the fault cycle. A loop in the style of a factorial gives many iterations of a backward conditional branch with in-place decrement of a local. Running it with a preloaded count of 13 makes the multiply wrap. The signed compare is exercised with a negative local, with equal operands under both branch forms, and with a non-taken case. All of these are checked cycle by cycle against a behavioural interpreter that uses a queue as its stack.

// File: rtl/stack_cpu_pkg.sv
package stack_cpu_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_ARG1,
        S_ARG2,
        S_EXEC
    } seq_state_t;

    typedef enum logic [3:0] {
        K_PUSHC, K_LOAD, K_STORE, K_ADD, K_MUL,
        K_INC, K_BLE, K_BLT, K_JMP, K_RET, K_BAD
    } op_kind_t;

    localparam logic [7:0] OPC_ADD = 8'h30;
    localparam logic [7:0] OPC_MUL = 8'h31;
    localparam logic [7:0] OPC_INC = 8'h40;
    localparam logic [7:0] OPC_BLE = 8'h50;
    localparam logic [7:0] OPC_BLT = 8'h51;
    localparam logic [7:0] OPC_JMP = 8'h52;
    localparam logic [7:0] OPC_RET = 8'h60;

    // need: entries that must be present; pop: entries removed; push: one entry added
    typedef struct packed {
        logic [1:0] need;
        logic [1:0] pop;
        logic       push;
    } stack_use_t;

    function automatic op_kind_t classify(input logic [7:0] b);
        op_kind_t k;
        if (b[7:3] == 5'b00010)       k = K_PUSHC;
        else if (b[7:2] == 6'b001000) k = K_LOAD;
        else if (b[7:2] == 6'b001001) k = K_STORE;
        else begin
            case (b)
                OPC_ADD: k = K_ADD;
                OPC_MUL: k = K_MUL;
                OPC_INC: k = K_INC;
                OPC_BLE: k = K_BLE;
                OPC_BLT: k = K_BLT;
                OPC_JMP: k = K_JMP;
                OPC_RET: k = K_RET;
                default: k = K_BAD;
            endcase
        end
        return k;
    endfunction

    function automatic logic is_long(input op_kind_t k);
        return (k == K_INC) || (k == K_BLE) || (k == K_BLT) || (k == K_JMP);
    endfunction

    function automatic stack_use_t stack_use(input op_kind_t k);
        stack_use_t u;
        case (k)
            K_PUSHC, K_LOAD: u = '{need: 2'd0, pop: 2'd0, push: 1'b1};
            K_STORE:         u = '{need: 2'd1, pop: 2'd1, push: 1'b0};
            K_ADD, K_MUL:    u = '{need: 2'd2, pop: 2'd2, push: 1'b1};
            K_BLE, K_BLT:    u = '{need: 2'd2, pop: 2'd2, push: 1'b0};
            K_RET:           u = '{need: 2'd1, pop: 2'd0, push: 1'b0};
            default:         u = '{need: 2'd0, pop: 2'd0, push: 1'b0};
        endcase
        return u;
    endfunction

endpackage

// File: rtl/stack_cpu_progmem.sv
module stack_cpu_progmem #(
    parameter int BYTES = 64,
    localparam int AW = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [BYTES];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/stack_cpu_locals.sv
module stack_cpu_locals #(
    parameter int DATA_W = 32,
    parameter int NUM_LOCALS = 4,
    localparam int LIDX_W = $clog2(NUM_LOCALS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_ext,
    input  logic [LIDX_W-1:0] idx_ext,
    input  logic [DATA_W-1:0] data_ext,
    input  logic              we_exec,
    input  logic [LIDX_W-1:0] idx_exec,
    input  logic [DATA_W-1:0] data_exec,
    input  logic [LIDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] regs [NUM_LOCALS];

    for (genvar i = 0; i < NUM_LOCALS; i++) begin : g_local
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (we_exec && idx_exec == LIDX_W'(i))
                regs[i] <= data_exec;
            else if (we_ext && idx_ext == LIDX_W'(i))
                regs[i] <= data_ext;
        end
    end

    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/stack_cpu_opstack.sv
module stack_cpu_opstack #(
    parameter int DATA_W = 32,
    parameter int DEPTH = 16,
    localparam int SP_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [1:0]        pop_cnt,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] top,
    output logic [DATA_W-1:0] second,
    output logic [SP_W-1:0]   depth
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [SP_W-1:0]   sp;
    logic [SP_W-1:0]   base;
    logic [IDX_W-1:0]  i_top, i_sec, i_wr;

    assign base  = sp - SP_W'(pop_cnt);
    assign i_top = IDX_W'(sp - SP_W'(1));
    assign i_sec = IDX_W'(sp - SP_W'(2));
    assign i_wr  = IDX_W'(base);

    always_ff @(posedge clk) begin
        if (rst || clear)
            sp <= '0;
        else
            sp <= base + SP_W'(push);
    end

    always_ff @(posedge clk) begin
        if (!rst && !clear && push) mem[i_wr] <= push_data;
    end

    assign top    = mem[i_top];
    assign second = mem[i_sec];
    assign depth  = sp;
endmodule

// File: rtl/stack_cpu.sv
module stack_cpu
    import stack_cpu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int STACK_DEPTH = 16,
    parameter int NUM_LOCALS = 4,
    parameter int PROG_BYTES = 64,
    localparam int AW = $clog2(PROG_BYTES),
    localparam int LIDX_W = $clog2(NUM_LOCALS),
    localparam int SP_W = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic [AW-1:0]     prog_addr,
    input  logic [7:0]        prog_data,
    input  logic              local_we,
    input  logic [LIDX_W-1:0] local_idx,
    input  logic [DATA_W-1:0] local_data,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [DATA_W-1:0] result
);
    seq_state_t        state;
    logic [15:0]       pc, op_pc;
    logic [7:0]        ir, arg_hi, arg_lo;
    logic [7:0]        fetch_byte;
    op_kind_t          kind;
    stack_use_t        use_s;
    logic [DATA_W-1:0] st_top, st_sec, loc_rd;
    logic [SP_W-1:0]   sp_depth;
    logic [7:0]        lsel;
    logic              bad_local, underflow, overflow, fault, exec_ok, taken;
    logic [15:0]       target, next_pc;
    logic [DATA_W-1:0] push_val, loc_wval;
    logic              loc_we_exec;
    logic              launch;

    assign busy   = (state != S_IDLE);
    assign launch = (state == S_IDLE) && start;

    stack_cpu_progmem #(.BYTES(PROG_BYTES)) u_prog (
        .clk(clk), .we(prog_we && !busy), .waddr(prog_addr), .wdata(prog_data),
        .raddr(pc[AW-1:0]), .rdata(fetch_byte)
    );

    // decode of the held instruction
    assign kind  = classify(ir);
    assign use_s = stack_use(kind);
    assign lsel  = (kind == K_INC) ? arg_hi : {6'd0, ir[1:0]};

    assign bad_local = ((kind == K_LOAD) || (kind == K_STORE) || (kind == K_INC))
                       && (lsel >= 8'(NUM_LOCALS));
    assign underflow = (sp_depth < SP_W'(use_s.need));
    assign overflow  = use_s.push && (use_s.pop == 2'd0) && (sp_depth == SP_W'(STACK_DEPTH));
    assign fault     = (kind == K_BAD) || bad_local || underflow || overflow;
    assign exec_ok   = (state == S_EXEC) && !fault;

    assign target = op_pc + {arg_hi, arg_lo};
    assign taken  = (kind == K_BLE) ? ($signed(st_sec) <= $signed(st_top))
                                    : ($signed(st_sec) <  $signed(st_top));

    always_comb begin
        push_val = '0;
        case (kind)
            K_PUSHC: push_val = DATA_W'(ir[2:0]);
            K_LOAD:  push_val = loc_rd;
            K_ADD:   push_val = st_sec + st_top;
            K_MUL:   push_val = st_sec * st_top;
            default: push_val = '0;
        endcase
    end

    always_comb begin
        loc_we_exec = 1'b0;
        loc_wval    = st_top;
        if (kind == K_STORE) begin
            loc_we_exec = exec_ok;
        end else if (kind == K_INC) begin
            loc_we_exec = exec_ok;
            loc_wval    = loc_rd + {{(DATA_W-8){arg_lo[7]}}, arg_lo};
        end
    end

    always_comb begin
        next_pc = pc;
        if (kind == K_JMP) next_pc = target;
        else if (((kind == K_BLE) || (kind == K_BLT)) && taken) next_pc = target;
    end

    stack_cpu_locals #(.DATA_W(DATA_W), .NUM_LOCALS(NUM_LOCALS)) u_locals (
        .clk(clk), .rst(rst),
        .we_ext(local_we && !busy), .idx_ext(local_idx), .data_ext(local_data),
        .we_exec(loc_we_exec), .idx_exec(LIDX_W'(lsel)), .data_exec(loc_wval),
        .rd_idx(LIDX_W'(lsel)), .rd_data(loc_rd)
    );

    stack_cpu_opstack #(.DATA_W(DATA_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst(rst), .clear(launch),
        .pop_cnt(exec_ok ? use_s.pop : 2'd0),
        .push(exec_ok && use_s.push), .push_data(push_val),
        .top(st_top), .second(st_sec), .depth(sp_depth)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            pc     <= '0;
            op_pc  <= '0;
            ir     <= '0;
            arg_hi <= '0;
            arg_lo <= '0;
            done   <= 1'b0;
            error  <= 1'b0;
            result <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    state  <= S_FETCH;
                    pc     <= '0;
                    done   <= 1'b0;
                    error  <= 1'b0;
                    result <= '0;
                end
                S_FETCH: begin
                    ir    <= fetch_byte;
                    op_pc <= pc;
                    pc    <= pc + 16'd1;
                    state <= is_long(classify(fetch_byte)) ? S_ARG1 : S_EXEC;
                end
                S_ARG1: begin
                    arg_hi <= fetch_byte;
                    pc     <= pc + 16'd1;
                    state  <= S_ARG2;
                end
                S_ARG2: begin
                    arg_lo <= fetch_byte;
                    pc     <= pc + 16'd1;
                    state  <= S_EXEC;
                end
                S_EXEC: begin
                    if (fault) begin
                        error <= 1'b1;
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else if (kind == K_RET) begin
                        result <= st_top;
                        done   <= 1'b1;
                        state  <= S_IDLE;
                    end else begin
                        pc    <= next_pc;
                        state <= S_FETCH;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/stack_cpu_check.sv
module stack_cpu_check #(
    parameter int DATA_W = 32,
    parameter int STACK_DEPTH = 16,
    localparam int SP_W = $clog2(STACK_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic [DATA_W-1:0] result,
    input logic [SP_W-1:0]   depth
);
    assert_busy_excludes_done_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    assert_start_launches_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done && !error && result == '0));

    assert_fault_halts_R9: assert property (@(posedge clk) disable iff (rst)
        error |-> (done && !busy));

    assert_result_held_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));

    assert_depth_bounded_R10: assert property (@(posedge clk) disable iff (rst)
        depth <= SP_W'(STACK_DEPTH));

    assert_depth_step_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> (int'(depth) <= int'($past(depth)) + 1));

    assert_idle_stack_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(depth));
endmodule

bind stack_cpu stack_cpu_check #(.DATA_W(DATA_W), .STACK_DEPTH(STACK_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .error(error), .result(result), .depth(sp_depth)
);

// File: tb/stack_cpu_test.sv
module stack_cpu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [7:0]  prog_data = '0;
    logic        local_we = 1'b0;
    logic [1:0]  local_idx = '0;
    logic [31:0] local_data = '0;
    logic        start = 1'b0;
    logic        busy, done, error;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;

    logic [7:0]         pq[$];
    logic [7:0]         prog_img [64];
    logic signed [31:0] mloc [4];

    always #2.5 clk = ~clk;

    stack_cpu uut (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .local_we(local_we), .local_idx(local_idx),
        .local_data(local_data), .start(start), .busy(busy), .done(done),
        .error(error), .result(result)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic load_prog();
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            prog_we   = 1'b1;
            prog_addr = 6'(a);
            prog_data = (a < pq.size()) ? pq[a] : 8'hFF;
            prog_img[a] = prog_data;
        end
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic set_local(input int i, input logic [31:0] v);
        @(negedge clk);
        local_we   = 1'b1;
        local_idx  = 2'(i);
        local_data = v;
        mloc[i]    = v;
        @(negedge clk);
        local_we = 1'b0;
    endtask

    // behavioural interpreter: instruction level, cycles counted per instruction length
    task automatic model(output int cyc, output logic err, output logic [31:0] res);
        logic signed [31:0] stk[$];
        logic signed [31:0] t, n;
        logic [15:0] pc, oa;
        logic [7:0]  op, a, b;
        bit fin;
        pc = 0; cyc = 0; err = 0; res = 0; fin = 0;
        for (int guard = 0; guard < 5000 && !fin; guard++) begin
            op = prog_img[pc[5:0]]; oa = pc; pc = pc + 1;
            a = 0; b = 0;
            if (op == 8'h40 || op == 8'h50 || op == 8'h51 || op == 8'h52) begin
                a = prog_img[pc[5:0]]; b = prog_img[6'(pc + 1)];
                pc = pc + 2; cyc += 4;
            end else cyc += 2;
            if (op >= 8'h10 && op <= 8'h17) begin
                if (stk.size() >= 16) begin err = 1; fin = 1; end
                else stk.push_back(32'(op - 8'h10));
            end else if (op >= 8'h20 && op <= 8'h23) begin
                if (stk.size() >= 16) begin err = 1; fin = 1; end
                else stk.push_back(mloc[op - 8'h20]);
            end else if (op >= 8'h24 && op <= 8'h27) begin
                if (stk.size() < 1) begin err = 1; fin = 1; end
                else mloc[op - 8'h24] = stk.pop_back();
            end else if (op == 8'h30 || op == 8'h31) begin
                if (stk.size() < 2) begin err = 1; fin = 1; end
                else begin
                    t = stk.pop_back(); n = stk.pop_back();
                    stk.push_back(op == 8'h30 ? n + t : n * t);
                end
            end else if (op == 8'h40) begin
                if (a >= 4) begin err = 1; fin = 1; end
                else mloc[a] = mloc[a] + 32'(signed'(b));
            end else if (op == 8'h50 || op == 8'h51) begin
                if (stk.size() < 2) begin err = 1; fin = 1; end
                else begin
                    t = stk.pop_back(); n = stk.pop_back();
                    if ((op == 8'h50) ? (n <= t) : (n < t)) pc = oa + {a, b};
                end
            end else if (op == 8'h52) begin
                pc = oa + {a, b};
            end else if (op == 8'h60) begin
                if (stk.size() < 1) err = 1;
                else res = stk[stk.size() - 1];
                fin = 1;
            end else begin
                err = 1; fin = 1;
            end
        end
    endtask

    task automatic run_case(input string tag);
        int n; logic e; logic [31:0] r; int bad;
        model(n, e, r);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        bad = 0;
        for (int j = 0; j <= n; j++) begin
            if (j > 0) @(negedge clk);
            if (busy !== (j < n) || done !== (j == n)) bad++;
        end
        check(bad == 0, tag, "per-cycle busy/done mismatches (R2)", 32'(bad), 32'd0);
        check(error === e, tag, "error", 32'(error), 32'(e));
        check(result === r, tag, "result", result, r);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    logic [7:0] factorial [19];
    assign factorial = '{8'h11, 8'h25, 8'h52, 8'h00, 8'h0A, 8'h21, 8'h20, 8'h31, 8'h25,
                         8'h40, 8'h00, 8'hFF, 8'h11, 8'h20, 8'h51, 8'hFF, 8'hF7, 8'h21, 8'h60};

    initial begin
        for (int i = 0; i < 4; i++) mloc[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy === 1'b0, "R1", "busy after reset", 32'(busy), 0);
        check(done === 1'b0, "R1", "done after reset", 32'(done), 0);
        check(error === 1'b0, "R1", "error after reset", 32'(error), 0);
        check(result === 32'd0, "R1", "result after reset", result, 0);

        // R1 locals zero: LOAD 3, RET
        pq = {8'h23, 8'h60}; load_prog(); run_case("R1 local3 zero");

        // factorial loop: R3 R4 R5 R6 R7 R12
        pq = {}; for (int i = 0; i < 19; i++) pq.push_back(factorial[i]);
        load_prog();
        set_local(0, 5);  run_case("R6 factorial 5");
        set_local(0, 13); run_case("R4 factorial 13 wraps");
        set_local(0, 1);  run_case("R6 factorial 1 no loop");
        // R12 loop counter left by previous run
        pq = {8'h20, 8'h21, 8'h30, 8'h60}; load_prog(); run_case("R12 locals persist");

        // signed compare, 0x50 form
        pq = {8'h20, 8'h21, 8'h50, 8'h00, 8'h05, 8'h10, 8'h60, 8'h11, 8'h60};
        load_prog();
        set_local(0, -3); set_local(1, 2);  run_case("R6 ble negative taken");
        set_local(0, 2);  set_local(1, 2);  run_case("R6 ble equal taken");
        set_local(0, 3);  set_local(1, -2); run_case("R6 ble not taken");
        // 0x51 form with equal operands
        pq[2] = 8'h51; load_prog();
        set_local(0, 2); set_local(1, 2);  run_case("R6 blt equal not taken");
        set_local(0, -7); set_local(1, -6); run_case("R6 blt negative taken");

        // R4 add and add wrap, R3 constants
        pq = {8'h17, 8'h15, 8'h30, 8'h60}; load_prog(); run_case("R4 add 7+5");
        set_local(0, 32'h7FFF_FFFF);
        pq = {8'h20, 8'h11, 8'h30, 8'h60}; load_prog(); run_case("R4 add wrap");
        set_local(2, 32'h8000_0000);
        pq = {8'h22, 8'h12, 8'h31, 8'h60}; load_prog(); run_case("R4 mul wrap");

        // R5 increment leaves stack, then R12 readback; also -128
        set_local(2, 10);
        pq = {8'h13, 8'h40, 8'h02, 8'h64, 8'h60}; load_prog(); run_case("R5 inc stack untouched");
        pq = {8'h22, 8'h60}; load_prog(); run_case("R5 inc value readback");
        pq = {8'h40, 8'h02, 8'h80, 8'h22, 8'h60}; load_prog(); run_case("R5 inc minus 128");
        pq = {8'h11, 8'h40, 8'h04, 8'h01, 8'h60}; load_prog(); run_case("R5 inc bad index");

        // R7 forward jump skipping a fault byte
        pq = {8'h12, 8'h52, 8'h00, 8'h04, 8'hFF, 8'h60}; load_prog(); run_case("R7 jump");

        // R9 exactly 16 pushes then return, then 17
        pq = {}; for (int i = 0; i < 16; i++) pq.push_back(8'h16);
        pq.push_back(8'h60); load_prog(); run_case("R9 sixteen pushes ok");
        pq = {}; for (int i = 0; i < 17; i++) pq.push_back(8'h14);
        pq.push_back(8'h60); load_prog(); run_case("R9 overflow");

        // R10 underflow forms
        pq = {8'h11, 8'h30, 8'h60}; load_prog(); run_case("R10 add underflow");
        pq = {8'h60}; load_prog(); run_case("R10 return empty");
        pq = {8'h11, 8'h50, 8'h00, 8'h03, 8'h60}; load_prog(); run_case("R10 branch underflow");
        pq = {8'h24, 8'h60}; load_prog(); run_case("R10 store empty");

        // R11 undefined opcodes
        pq = {8'h11, 8'h00}; load_prog(); run_case("R11 opcode 00");
        pq = {8'h12, 8'hFF}; load_prog(); run_case("R11 opcode FF");
        pq = {8'h13, 8'h61, 8'h60}; load_prog(); run_case("R11 opcode 61");

        // R8 result held while idle
        repeat (5) @(negedge clk);
        check(result === 32'd0 && done === 1'b1, "R8", "result held after fault run",
              result, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule